// File: doc/BRIEF.md
# Control Transfer History Ring

This block keeps a circular history of the most recent control-flow transfers taken by a processor core. Each record holds a source address, a target address and a 4-bit transfer type. A core-side strobe offers one transfer per cycle together with the privilege level it was taken in. A control register decides whether the transfer is kept. It holds per-privilege enables, per-type inhibits, a return-stack emulation mode and a freeze flag.

Software reads the history through an indexed port. The select value 0x200 plus N returns logical record N, and record 0 is always the newest. The physical location of each record follows from a wrapping write pointer. A depth code selects a ring size of 16, 32, 64, 128 or 256 records, limited to the sizes the build enables. A clear command is checked against the privilege of its issuer before it wipes the history.

In return-stack emulation mode the ring works as a call stack. A return removes the newest record, and a coroutine swap replaces the newest record with the new one.

Top module: `xfer_history_ring`

## Requirements
- R1: After reset the control register reads 0, the write pointer is 0, every record reads invalid, and the depth code is the lowest code enabled in DEPTH_MAP.
- R2: A kept transfer stores source, target and type with its valid bit set at the write pointer on the next clock edge, and the pointer advances by one modulo the current ring size.
- R3: Select 0x200|N reads the physical record (pointer − N − 1) mod ring size, so N=0 is the newest record; once the ring has wrapped, the oldest records are overwritten.
- R4: rd_hit is 1 only when rd_sel[11:8] equals 2 and rd_sel[7:0] is below the ring size (16 << depth code). When rd_hit is 0, or the addressed record is invalid, rd_vld, rd_src, rd_dst and rd_type all read 0.
- R5: A transfer is kept only when the enable bit for its privilege is set (ctl bit 16 user, ev_priv 0; bit 17 supervisor, ev_priv 1; bit 18 machine, ev_priv 3) and the frozen bit (ctl bit 20) is clear. ev_priv 2 is never kept.
- R6: Outside stack mode, ctl bit T (T = 0..15) inhibits transfers of type T. An inhibited transfer leaves the pointer and all records unchanged.
- R7: With stack mode on (ctl bit 19), an active transfer of type 13 (return) decrements the pointer modulo the ring size and clears the valid bit of the record it then points to. The type-13 inhibit bit has no effect on this.
- R8: With stack mode on, an active type-12 transfer (coroutine swap) overwrites the record just below the pointer and sets its valid bit, and the pointer does not move. An active type-15 transfer (direct jump with linkage) changes nothing. Other types are kept as in R2 and R6.
- R9: A clear is illegal from user privilege (clr_priv 0), from privilege code 2, and from supervisor (clr_priv 1) when clr_state_en is 0. An illegal clear drives clr_illegal high in the same cycle and changes no state.
- R10: A legal clear invalidates every record and sets the pointer to 0 at the next edge. It takes priority over a transfer offered in the same cycle.
- R11: ctl_wdata is stored into the control register and read back on ctl_rdata. When OVF_SUPPORT is 0, the overflow-freeze bit (ctl bit 21) always reads 0.
- R12: A depth write with a code that is enabled in DEPTH_MAP and differs from the current code changes the ring size, sets the pointer to 0 and invalidates every record. A write of a disabled code, or of the current code, has no effect. A depth change takes priority over a clear or a transfer in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | A transfer is offered this cycle |
| ev_type | input | 4 | Transfer type code |
| ev_priv | input | 2 | Privilege of the transfer (0 U, 1 S, 3 M) |
| ev_src | input | ADDR_W | Source address |
| ev_dst | input | ADDR_W | Target address |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 22 | Control value to write |
| ctl_rdata | output | 22 | Current control register |
| depth_we | input | 1 | Write strobe for the depth code |
| depth_wcode | input | 3 | Requested depth code |
| depth_code | output | 3 | Current depth code |
| clr_req | input | 1 | Clear command |
| clr_priv | input | 2 | Privilege issuing the clear |
| clr_state_en | input | 1 | State-enable bit that permits a supervisor clear |
| clr_illegal | output | 1 | Clear rejected as illegal (same cycle) |
| rd_sel | input | 12 | Read select value |
| rd_hit | output | 1 | Select value is in range |
| rd_vld | output | 1 | Selected record is valid |
| rd_src | output | ADDR_W | Selected source address |
| rd_dst | output | ADDR_W | Selected target address |
| rd_type | output | 4 | Selected transfer type |
| wr_ptr | output | 8 | Current write pointer, zero-extended |

## Verification
The bench builds the block with ADDR_W=16, DEPTH_MAP=5'b00011 and OVF_SUPPORT=0. With only 16- and 32-record rings, a few hundred random transfers wrap the ring many times at both sizes. Writes of depth code 2 exercise the path for disabled codes, and the overflow-freeze bit must read back as zero. Every scan also covers selects 32 to 34, which lie beyond the largest ring, and a select with the wrong upper nibble.

// File: rtl/xhr_pkg.sv
package xhr_pkg;
  localparam int CTL_W   = 22;
  localparam int B_EN_U  = 16;
  localparam int B_EN_S  = 17;
  localparam int B_EN_M  = 18;
  localparam int B_STACK = 19;
  localparam int B_FRZ   = 20;
  localparam int B_OVF   = 21;

  localparam logic [3:0] XT_SWAP    = 4'd12;
  localparam logic [3:0] XT_RETURN  = 4'd13;
  localparam logic [3:0] XT_DIRLINK = 4'd15;

  localparam logic [1:0] PV_U = 2'd0;
  localparam logic [1:0] PV_S = 2'd1;
  localparam logic [1:0] PV_M = 2'd3;

  function automatic logic [8:0] ring_size(input logic [2:0] code);
    return 9'd16 << code;
  endfunction

  function automatic logic code_ok(input logic [4:0] map, input logic [2:0] code);
    return (code < 3'd5) && map[code];
  endfunction

  function automatic logic [2:0] lowest_code(input logic [4:0] map);
    logic [2:0] r;
    r = 3'd0;
    for (int i = 4; i >= 0; i--) if (map[i]) r = 3'(i);
    return r;
  endfunction

  function automatic logic [2:0] highest_code(input logic [4:0] map);
    logic [2:0] r;
    r = 3'd0;
    for (int i = 0; i < 5; i++) if (map[i]) r = 3'(i);
    return r;
  endfunction

  // newest-first logical index to physical slot
  function automatic logic [7:0] phys_slot(input logic [7:0] ptr, input logic [7:0] n,
                                           input logic [7:0] mask);
    return (ptr - n - 8'd1) & mask;
  endfunction
endpackage

// File: rtl/xhr_ctl_reg.sv
module xhr_ctl_reg
  import xhr_pkg::*;
#(
  parameter bit OVF_SUPPORT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl_q
);
  localparam logic [CTL_W-1:0] KEEP_MASK =
    OVF_SUPPORT ? {CTL_W{1'b1}} : ~(CTL_W'(1) << B_OVF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (we) ctl_q <= wdata & KEEP_MASK;
  end

  generate
    if (!OVF_SUPPORT) begin : g_no_ovf
      a_r11_ovf_zero: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !ctl_q[B_OVF]);
    end
  endgenerate
endmodule

// File: rtl/xhr_ptr_ctl.sv
module xhr_ptr_ctl
  import xhr_pkg::*;
#(
  parameter logic [4:0] DEPTH_MAP = 5'b11111,
  parameter int         PTR_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [3:0]       ev_type,
  input  logic [1:0]       ev_priv,
  input  logic [15:0]      inhibit,
  input  logic [2:0]       priv_en,
  input  logic             stack_mode,
  input  logic             frozen,
  input  logic             depth_we,
  input  logic [2:0]       depth_wcode,
  input  logic             clr_req,
  input  logic [1:0]       clr_priv,
  input  logic             clr_state_en,
  output logic [PTR_W-1:0] ptr_q,
  output logic [2:0]       dcode_q,
  output logic             flush,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx,
  output logic             inval_en,
  output logic [PTR_W-1:0] inval_idx,
  output logic             clr_illegal
);
  logic [PTR_W-1:0] mask, ptr_dec, ptr_inc, ptr_d;
  logic priv_on, active, clr_ok;
  logic do_depth, do_clear, ev_go, do_push, do_pop, do_swap;
  logic is_ret, is_swap, is_dlink;

  assign mask    = PTR_W'(ring_size(dcode_q) - 9'd1);
  assign ptr_dec = (ptr_q - PTR_W'(1)) & mask;
  assign ptr_inc = (ptr_q + PTR_W'(1)) & mask;

  always_comb begin
    unique case (ev_priv)
      PV_U:    priv_on = priv_en[0];
      PV_S:    priv_on = priv_en[1];
      PV_M:    priv_on = priv_en[2];
      default: priv_on = 1'b0;
    endcase
  end

  assign active   = ev_valid && priv_on && !frozen;
  assign is_ret   = (ev_type == XT_RETURN);
  assign is_swap  = (ev_type == XT_SWAP);
  assign is_dlink = (ev_type == XT_DIRLINK);

  assign clr_ok      = clr_req && ((clr_priv == PV_M) || (clr_priv == PV_S && clr_state_en));
  assign clr_illegal = clr_req && !clr_ok;

  assign do_depth = depth_we && code_ok(DEPTH_MAP, depth_wcode) && (depth_wcode != dcode_q);
  assign do_clear = !do_depth && clr_ok;
  assign ev_go    = !do_depth && !do_clear && active;
  assign do_pop   = ev_go && stack_mode && is_ret;
  assign do_swap  = ev_go && stack_mode && is_swap;
  assign do_push  = ev_go && !(stack_mode && (is_ret || is_swap || is_dlink)) && !inhibit[ev_type];

  assign flush     = do_depth || do_clear;
  assign wr_en     = do_push || do_swap;
  assign wr_idx    = do_swap ? ptr_dec : ptr_q;
  assign inval_en  = do_pop;
  assign inval_idx = ptr_dec;

  always_comb begin
    ptr_d = ptr_q;
    if (flush)       ptr_d = '0;
    else if (do_push) ptr_d = ptr_inc;
    else if (do_pop)  ptr_d = ptr_dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      dcode_q <= lowest_code(DEPTH_MAP);
    end else begin
      ptr_q <= ptr_d;
      if (do_depth) dcode_q <= depth_wcode;
    end
  end

  a_r2_push_advance: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> ptr_q == (($past(ptr_q) + PTR_W'(1)) & $past(mask)));
  a_r7_pop_retreat: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |=> ptr_q == (($past(ptr_q) - PTR_W'(1)) & $past(mask)));
  a_r8_swap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    do_swap |=> $stable(ptr_q));
  a_r10_clear_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    do_clear |=> ptr_q == '0);
  a_r9_illegal_still: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_illegal && !ev_valid && !depth_we) |=> $stable(ptr_q) && $stable(dcode_q));
  a_r12_depth_legal: assert property (@(posedge clk) disable iff (!rst_n)
    code_ok(DEPTH_MAP, dcode_q));
  a_r5_frozen_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> !wr_en && !inval_en);
  a_r3_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q & ~mask) == '0);
endmodule

// File: rtl/xhr_store.sv
module xhr_store #(
  parameter int ADDR_W  = 32,
  parameter int MAX_ENT = 256,
  parameter int PTR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_src,
  input  logic [ADDR_W-1:0] wr_dst,
  input  logic [3:0]        wr_typ,
  input  logic              inval_en,
  input  logic [PTR_W-1:0]  inval_idx,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_src,
  output logic [ADDR_W-1:0] rd_dst,
  output logic [3:0]        rd_typ,
  output logic              rd_vld
);
  logic [ADDR_W-1:0] src_mem [MAX_ENT];
  logic [ADDR_W-1:0] dst_mem [MAX_ENT];
  logic [3:0]        typ_mem [MAX_ENT];
  logic [MAX_ENT-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      src_mem[wr_idx] <= wr_src;
      dst_mem[wr_idx] <= wr_dst;
      typ_mem[wr_idx] <= wr_typ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (flush) vld_q <= '0;
    else begin
      if (wr_en)    vld_q[wr_idx]    <= 1'b1;
      if (inval_en) vld_q[inval_idx] <= 1'b0;
    end
  end

  assign rd_src = src_mem[rd_idx];
  assign rd_dst = dst_mem[rd_idx];
  assign rd_typ = typ_mem[rd_idx];
  assign rd_vld = vld_q[rd_idx];

  a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> $countones(vld_q) == 0);
  a_r7_pop_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_en && !flush) |=> !vld_q[$past(inval_idx)]);
  a_r2_write_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/xfer_history_ring.sv
module xfer_history_ring
  import xhr_pkg::*;
#(
  parameter int         ADDR_W      = 32,
  parameter logic [4:0] DEPTH_MAP   = 5'b11111,
  parameter bit         OVF_SUPPORT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [3:0]        ev_type,
  input  logic [1:0]        ev_priv,
  input  logic [ADDR_W-1:0] ev_src,
  input  logic [ADDR_W-1:0] ev_dst,
  input  logic              ctl_we,
  input  logic [21:0]       ctl_wdata,
  output logic [21:0]       ctl_rdata,
  input  logic              depth_we,
  input  logic [2:0]        depth_wcode,
  output logic [2:0]        depth_code,
  input  logic              clr_req,
  input  logic [1:0]        clr_priv,
  input  logic              clr_state_en,
  output logic              clr_illegal,
  input  logic [11:0]       rd_sel,
  output logic              rd_hit,
  output logic              rd_vld,
  output logic [ADDR_W-1:0] rd_src,
  output logic [ADDR_W-1:0] rd_dst,
  output logic [3:0]        rd_type,
  output logic [7:0]        wr_ptr
);
  localparam int MAX_ENT = 16 << highest_code(DEPTH_MAP);
  localparam int PTR_W   = $clog2(MAX_ENT);

  logic [CTL_W-1:0]  ctl_q;
  logic [PTR_W-1:0]  ptr_q, wr_idx, inval_idx, rd_idx;
  logic [2:0]        dcode_q;
  logic              flush, wr_en, inval_en;
  logic [ADDR_W-1:0] st_src, st_dst;
  logic [3:0]        st_typ;
  logic              st_vld, sel_ok;
  logic [7:0]        rd_mask;

  xhr_ctl_reg #(.OVF_SUPPORT(OVF_SUPPORT)) ctl_i (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata), .ctl_q(ctl_q));

  xhr_ptr_ctl #(.DEPTH_MAP(DEPTH_MAP), .PTR_W(PTR_W)) ptr_i (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_type(ev_type), .ev_priv(ev_priv),
    .inhibit(ctl_q[15:0]), .priv_en(ctl_q[B_EN_M:B_EN_U]),
    .stack_mode(ctl_q[B_STACK]), .frozen(ctl_q[B_FRZ]),
    .depth_we(depth_we), .depth_wcode(depth_wcode),
    .clr_req(clr_req), .clr_priv(clr_priv), .clr_state_en(clr_state_en),
    .ptr_q(ptr_q), .dcode_q(dcode_q), .flush(flush),
    .wr_en(wr_en), .wr_idx(wr_idx), .inval_en(inval_en), .inval_idx(inval_idx),
    .clr_illegal(clr_illegal));

  xhr_store #(.ADDR_W(ADDR_W), .MAX_ENT(MAX_ENT), .PTR_W(PTR_W)) store_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_src(ev_src), .wr_dst(ev_dst), .wr_typ(ev_type),
    .inval_en(inval_en), .inval_idx(inval_idx), .rd_idx(rd_idx),
    .rd_src(st_src), .rd_dst(st_dst), .rd_typ(st_typ), .rd_vld(st_vld));

  assign rd_mask = 8'(ring_size(dcode_q) - 9'd1);
  assign rd_idx  = PTR_W'(phys_slot(8'(ptr_q), rd_sel[7:0], rd_mask));
  assign rd_hit  = (rd_sel[11:8] == 4'h2) && ({1'b0, rd_sel[7:0]} < ring_size(dcode_q));
  assign sel_ok  = rd_hit && st_vld;
  assign rd_vld  = sel_ok;
  assign rd_src  = sel_ok ? st_src : '0;
  assign rd_dst  = sel_ok ? st_dst : '0;
  assign rd_type = sel_ok ? st_typ : '0;

  assign ctl_rdata  = ctl_q;
  assign depth_code = dcode_q;
  assign wr_ptr     = 8'(ptr_q);

  a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> !rd_vld && rd_src == '0 && rd_dst == '0 && rd_type == '0);
  a_r9_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && clr_priv == PV_U) |-> clr_illegal);
endmodule

// File: tb/xfer_history_ring_tb_top.sv
module xfer_history_ring_tb_top;
  localparam int AW = 16;
  localparam logic [4:0] MAP = 5'b00011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 0; logic [3:0] ev_type = 0; logic [1:0] ev_priv = 0;
  logic [AW-1:0] ev_src = 0, ev_dst = 0;
  logic ctl_we = 0; logic [21:0] ctl_wdata = 0; logic [21:0] ctl_rdata;
  logic depth_we = 0; logic [2:0] depth_wcode = 0; logic [2:0] depth_code;
  logic clr_req = 0; logic [1:0] clr_priv = 0; logic clr_state_en = 0; logic clr_illegal;
  logic [11:0] rd_sel = 0; logic rd_hit, rd_vld;
  logic [AW-1:0] rd_src, rd_dst; logic [3:0] rd_type; logic [7:0] wr_ptr;

  always #2 clk = ~clk;

  xfer_history_ring #(.ADDR_W(AW), .DEPTH_MAP(MAP), .OVF_SUPPORT(1'b0)) dut_i (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  logic [AW-1:0] m_src [32];
  logic [AW-1:0] m_dst [32];
  logic [3:0]    m_typ [32];
  logic [31:0]   m_vld = '0;
  int            m_ptr = 0, m_dc = 0;
  logic [21:0]   m_ctl = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ents(); return 16 << m_dc; endfunction
  function automatic bit clr_legal(input logic [1:0] p, input logic se);
    return (p == 2'd3) || (p == 2'd1 && se);
  endfunction
  function automatic bit code_allowed(input logic [2:0] c);
    return c < 5 && MAP[c];
  endfunction

  task automatic model_apply();
    bit stk, act, pe;
    int msk, p;
    msk = ents() - 1;
    stk = m_ctl[19];
    case (ev_priv)
      2'd0: pe = m_ctl[16];
      2'd1: pe = m_ctl[17];
      2'd3: pe = m_ctl[18];
      default: pe = 0;
    endcase
    act = ev_valid && pe && !m_ctl[20];
    if (depth_we && code_allowed(depth_wcode) && int'(depth_wcode) != m_dc) begin
      m_dc = int'(depth_wcode); m_ptr = 0; m_vld = '0;
    end else if (clr_req && clr_legal(clr_priv, clr_state_en)) begin
      m_ptr = 0; m_vld = '0;
    end else if (act) begin
      if (stk && ev_type == 4'd13) begin
        m_ptr = (m_ptr - 1) & msk; m_vld[m_ptr] = 0;
      end else if (stk && ev_type == 4'd12) begin
        p = (m_ptr - 1) & msk;
        m_src[p] = ev_src; m_dst[p] = ev_dst; m_typ[p] = ev_type; m_vld[p] = 1;
      end else if (stk && ev_type == 4'd15) begin
        // nothing kept
      end else if (!m_ctl[ev_type]) begin
        m_src[m_ptr] = ev_src; m_dst[m_ptr] = ev_dst; m_typ[m_ptr] = ev_type; m_vld[m_ptr] = 1;
        m_ptr = (m_ptr + 1) & msk;
      end
    end
    if (ctl_we) m_ctl = ctl_wdata & ~(22'd1 << 21);
  endtask

  task automatic tick();
    @(posedge clk);
    model_apply();
    #1;
  endtask

  task automatic scan(input string req);
    logic [63:0] got, exp;
    int p, n;
    for (int i = 0; i < 36; i++) begin
      n = (i < 35) ? i : 0;
      rd_sel = (i < 35) ? (12'h200 | 12'(n)) : 12'h300;
      #0.5;
      got = {26'd0, rd_hit, rd_vld, rd_type, rd_src, rd_dst};
      p = (m_ptr - n - 1) & (ents() - 1);
      if (i < 35 && n < ents()) begin
        if (m_vld[p]) exp = {26'd0, 1'b1, 1'b1, m_typ[p], m_src[p], m_dst[p]};
        else exp = {26'd0, 1'b1, 1'b0, 4'd0, 16'd0, 16'd0};
      end else exp = 64'd0;
      chk(got == exp, {req, " R3/R4 read"}, got, exp);
    end
    chk(wr_ptr == 8'(m_ptr), {req, " R2 pointer"}, 64'(wr_ptr), 64'(m_ptr));
    chk(ctl_rdata == m_ctl, {req, " R11 ctl"}, 64'(ctl_rdata), 64'(m_ctl));
    chk(depth_code == 3'(m_dc), {req, " R12 depth"}, 64'(depth_code), 64'(m_dc));
  endtask

  task automatic event_go(input logic [3:0] t, input logic [1:0] p, input logic [AW-1:0] s, input logic [AW-1:0] d);
    ev_valid = 1; ev_type = t; ev_priv = p; ev_src = s; ev_dst = d;
    tick();
    ev_valid = 0;
  endtask

  task automatic ctl_write(input logic [21:0] v);
    ctl_we = 1; ctl_wdata = v; tick(); ctl_we = 0;
  endtask

  task automatic clear_go(input logic [1:0] p, input logic se, input string req);
    bit expi;
    clr_req = 1; clr_priv = p; clr_state_en = se;
    #0.5;
    expi = !clr_legal(p, se);
    chk(clr_illegal == expi, req, 64'(clr_illegal), 64'(expi));
    tick();
    clr_req = 0;
  endtask

  task automatic depth_go(input logic [2:0] c);
    depth_we = 1; depth_wcode = c; tick(); depth_we = 0;
  endtask

  localparam logic [21:0] EN_ALL = 22'h07_0000;

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1 reset state
    chk(ctl_rdata == 0, "R1 ctl reset", 64'(ctl_rdata), 0);
    chk(wr_ptr == 0, "R1 ptr reset", 64'(wr_ptr), 0);
    chk(depth_code == 0, "R1 depth reset", 64'(depth_code), 0);
    scan("R1");

    // R5 nothing kept while all enables are off
    event_go(4'd5, 2'd3, 16'h1111, 16'h2222);
    scan("R5 disabled");

    ctl_write(EN_ALL);
    // R2/R3 fill past one wrap of the 16-entry ring
    for (int i = 0; i < 20; i++) event_go(4'(i % 12), 2'(i % 2), 16'(16'h1000 + i), 16'(16'h8000 + 3*i));
    scan("R2 wrap");

    // R5 reserved privilege code and freeze
    event_go(4'd4, 2'd2, 16'hdead, 16'hbeef);
    ctl_write(EN_ALL | 22'h10_0000);
    event_go(4'd4, 2'd3, 16'hdead, 16'hbeef);
    scan("R5 frozen");
    // R6 inhibit type 5
    ctl_write(EN_ALL | 22'h00_0020);
    event_go(4'd5, 2'd1, 16'h0505, 16'h5050);
    scan("R6 inhibit");
    event_go(4'd6, 2'd1, 16'h0606, 16'h6060);
    scan("R6 other type");

    // R7/R8 stack mode (return inhibit set to show it has no effect)
    ctl_write(EN_ALL | 22'h08_0000 | 22'h00_2000);
    event_go(4'd9, 2'd3, 16'h0909, 16'h9090);
    event_go(4'd13, 2'd3, 16'h0d0d, 16'hd0d0);
    scan("R7 pop");
    event_go(4'd12, 2'd3, 16'h0c0c, 16'hc0c0);
    scan("R8 swap");
    event_go(4'd15, 2'd3, 16'h0f0f, 16'hf0f0);
    scan("R8 dirlink");
    for (int i = 0; i < 20; i++) event_go(4'd13, 2'd0, 16'h0, 16'h0);
    scan("R7 pop run");

    // R11 overflow bit
    ctl_write(22'h3f_ffff);
    scan("R11 ones");

    // R9 illegal clears
    ctl_write(EN_ALL);
    for (int i = 0; i < 5; i++) event_go(4'd2, 2'd0, 16'(i), 16'(i + 7));
    clear_go(2'd0, 1'b1, "R9 user clear");
    clear_go(2'd1, 1'b0, "R9 sup clear no enable");
    clear_go(2'd2, 1'b1, "R9 reserved clear");
    scan("R9 unchanged");
    // R10 legal clear beats a same-cycle event
    ev_valid = 1; ev_type = 4'd3; ev_priv = 2'd3; ev_src = 16'h3333; ev_dst = 16'h4444;
    clear_go(2'd1, 1'b1, "R10 sup clear");
    ev_valid = 0;
    scan("R10 cleared");
    for (int i = 0; i < 3; i++) event_go(4'd1, 2'd3, 16'(i), 16'(i));
    clear_go(2'd3, 1'b0, "R10 m clear");
    scan("R10 m cleared");

    // R12 depth
    for (int i = 0; i < 7; i++) event_go(4'd1, 2'd3, 16'(i + 40), 16'(i));
    depth_go(3'd2);
    scan("R12 disabled code");
    depth_go(3'd0);
    scan("R12 same code");
    depth_go(3'd1);
    scan("R12 change");
    for (int i = 0; i < 40; i++) event_go(4'd8, 2'd1, 16'(i + 100), 16'(i + 200));
    scan("R3 wrap 32");

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 5) begin
        logic [21:0] v;
        v = 22'($urandom) & 22'h3f_ffff;
        if (($urandom % 8) != 0) v[20] = 0;
        v[15:0] = v[15:0] & 16'($urandom);
        ctl_write(v);
      end else if (r < 8) begin
        clear_go(2'($urandom), 1'($urandom), "R9 random clear");
      end else if (r < 10) begin
        depth_go(3'($urandom % 3));
      end else begin
        logic [1:0] p;
        p = ($urandom % 6 == 0) ? 2'd2 : ((($urandom % 3) == 0) ? 2'd0 : (($urandom % 2) ? 2'd1 : 2'd3));
        event_go(4'($urandom), p, 16'($urandom), 16'($urandom));
      end
      if (i % 40 == 39) scan("random");
    end
    scan("final");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule